// File: doc/BRIEF.md
# Buffered Input-Capture Timer

This block timestamps events on four capture inputs against a 16-bit counter that runs freely from reset. Each input has its own edge-select bit, capture register, capture flag and interrupt enable. A flag whose enable is set raises the single interrupt output.

Two mode bits pair the channels. In buffered mode, channel C holds the previous capture of channel A, and channel D does the same for channel B. A capture on the main channel of a pair then moves its old value into the partner register and loads the counter in the same clock. Edges on the partner's own input still set the partner's flag, but they no longer load its register.

Software reads the registers through an 8-bit port, upper byte first. Reading the upper byte latches the lower byte, so the 16-bit result is consistent. A buffered capture that would load a register whose upper byte is being read in that clock is held back by exactly one clock.

Top module: `cap_unit`

## Requirements
- R1: The counter is 16 bits wide. It is 0 in the first clock after reset, rises by 1 every clock and wraps from 16'hFFFF to 0.
- R2: Channel index 0=A, 1=B, 2=C, 3=D. When `edge_sel[i]` is 1, a 0-to-1 change of `cap_in[i]` triggers the channel; when it is 0, a 1-to-0 change triggers it. A change is detected against the input's value in the previous clock, and that stored value is 0 after reset. The opposite change has no effect.
- R3: When `buf_mode` is 0 for a pair, a trigger on channel i loads that clock's counter value into register i and sets `flags[i]` at the same clock edge.
- R4: Buffered mode is selected by `buf_mode[0]` for the A/C pair and by `buf_mode[1]` for the B/D pair. In buffered mode, a trigger on A (B) moves A's (B's) old value into C (D) and loads the counter into A (B) at the same edge. It sets flag A (B) and leaves flag C (D) unchanged.
- R5: In buffered mode, a trigger on C (D) sets `flags[2]` (`flags[3]`) and leaves register C (D) unchanged.
- R6: In buffered mode, the pair's transfer is delayed when `rd_en` is 1, `rd_addr[0]` is 0 and `rd_addr[2:1]` names either register of the pair in the clock the transfer would occur. The transfer then happens exactly one clock later, using that later clock's counter value, and the main flag is set then. A lower-byte read causes no delay.
- R7: `rd_addr[2:1]` selects the register and `rd_addr[0]` selects the byte (0 = upper, 1 = lower). An upper read returns the upper byte in the same cycle and latches the register's lower byte. A lower read returns the latched byte, even if the register has changed since. `rd_data` is 0 while `rd_en` is 0.
- R8: A `flag_rd` pulse arms every flag that is 1. A `flag_wr` pulse clears each armed flag whose `flag_wdata` bit is 0, and then disarms all flags. A flag that is not armed is not cleared.
- R9: A trigger that sets a flag in the same clock as a clear of that flag wins, and the flag stays 1.
- R10: `irq` is 1 exactly when some `flags[i]` and `irq_en[i]` are both 1.
- R11: After reset, all capture registers, `flags` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_in | input | 4 | Synchronised capture inputs, A..D |
| edge_sel | input | 4 | Per-channel edge select, 1 = rising |
| buf_mode | input | 2 | Buffered mode for A/C (bit 0) and B/D (bit 1) |
| irq_en | input | 4 | Per-channel interrupt enable |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 3 | Register (bits 2:1) and byte (bit 0) select |
| rd_data | output | 8 | Read data |
| flag_rd | input | 1 | Flag read strobe, arms set flags |
| flag_wr | input | 1 | Flag write strobe |
| flag_wdata | input | 4 | Flag write data, 0 clears an armed flag |
| flags | output | 4 | Capture flags |
| irq | output | 1 | Interrupt request |

## Verification
A capture on a buffered main channel can fall in the same clock as a CPU upper-byte read of either register in its pair. The bench provokes this by raising the capture input and driving the upper-byte read on the same falling edge. It then requires the flag to stay clear after one clock, to be set after two, and the main register to hold the counter value plus one. A capture can also meet a flag clear in the same clock. The bench arms the flag, issues the clear together with a new edge, and requires the flag to remain set.

// File: rtl/cap_pkg.sv
// Shared constants and channel naming for the buffered input-capture timer.
package cap_pkg;
    localparam int CNT_W  = 16;
    localparam int BYTE_W = 8;
    localparam int N_CH   = 4;
    localparam int N_PAIR = N_CH / 2;

    typedef enum logic [1:0] {
        CH_A = 2'd0,
        CH_B = 2'd1,
        CH_C = 2'd2,
        CH_D = 2'd3
    } chan_e;
endpackage

// File: rtl/cap_counter.sv
// Free-running up counter that wraps at its width.
// Assumes: synchronous active-low reset; no clear or prescale.
module cap_counter #(
    parameter int W = cap_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] cnt
);
    // Count one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt + 1'b1;
    end

    // R1: the counter advances by exactly one each clock.
    a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> cnt == W'($past(cnt) + 1'b1));
endmodule

// File: rtl/cap_edge.sv
// Per-channel edge detector with a selectable polarity.
// Assumes: inputs are already synchronised to clk; stored history resets to 0.
module cap_edge #(
    parameter int N = cap_pkg::N_CH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cap_in,
    input  logic [N-1:0] edge_sel,
    output logic [N-1:0] ev
);
    logic [N-1:0] prev;

    // Keep last clock's input value.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= cap_in;
    end

    // Trigger on a rising change when selected, otherwise on a falling one.
    always_comb begin
        ev = (cap_in & ~prev & edge_sel) | (~cap_in & prev & ~edge_sel);
    end
endmodule

// File: rtl/cap_pair.sv
// One main/partner channel pair: capture registers, buffered transfer and
// the one-clock postponement when an upper-byte read collides.
// Assumes: ev_* are single-clock trigger pulses; rd_hit marks an upper-byte
// read of either register of this pair in the current clock.
module cap_pair #(
    parameter int W = cap_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cnt,
    input  logic         ev_main,
    input  logic         ev_part,
    input  logic         buf_en,
    input  logic         rd_hit,
    output logic [W-1:0] main_q,
    output logic [W-1:0] part_q,
    output logic         set_main,
    output logic         set_part
);
    logic pend;
    logic do_main;
    logic hold;

    // Decide whether the main capture happens now or is postponed.
    always_comb begin
        hold     = ev_main & buf_en & rd_hit & ~pend;
        do_main  = (ev_main & ~hold) | pend;
        set_main = do_main;
        set_part = ev_part;
    end

    // Remember a postponed capture for exactly one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= hold;
    end

    // Load the capture registers; in buffered mode shift main into partner.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            main_q <= '0;
            part_q <= '0;
        end else begin
            if (do_main) main_q <= cnt;
            if (buf_en) begin
                if (do_main) part_q <= main_q;
            end else if (ev_part) begin
                part_q <= cnt;
            end
        end
    end

    // R4: a buffered capture moves the old main value into the partner.
    a_r4_shift: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en && do_main |=> part_q == $past(main_q));
    // R5: a partner edge in buffered mode leaves the partner register alone.
    a_r5_part_hold: assert property (@(posedge clk) disable iff (!rst_n)
        buf_en && ev_part && !do_main |=> $stable(part_q));
    // R6: a colliding capture leaves the main register unchanged for one clock.
    a_r6_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ev_main && buf_en && rd_hit && !pend |=> $stable(main_q));
    // R3: without a trigger or a pending capture the main register holds.
    a_r3_main_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ev_main && !pend |=> $stable(main_q));
endmodule

// File: rtl/cap_rdport.sv
// Byte-wide read port, upper byte first, with a latched lower byte.
// Assumes: W is two bytes; caps packs the N registers, channel 0 lowest.
module cap_rdport #(
    parameter int W  = cap_pkg::CNT_W,
    parameter int BW = cap_pkg::BYTE_W,
    parameter int N  = cap_pkg::N_CH,
    localparam int SW = $clog2(N),
    localparam int AW = SW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N*W-1:0] caps,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [BW-1:0] rd_data,
    output logic [N-1:0]  hit_hi
);
    logic [SW-1:0] sel;
    logic [W-1:0]  word;
    logic [BW-1:0] lo_latch;
    logic          rd_hi;

    // Select the addressed register and form the read data.
    always_comb begin
        sel     = rd_addr[AW-1:1];
        word    = caps[sel*W +: W];
        rd_hi   = rd_en & ~rd_addr[0];
        rd_data = '0;
        if (rd_en) rd_data = rd_addr[0] ? lo_latch : word[W-1 -: BW];
        hit_hi  = '0;
        if (rd_hi) hit_hi[sel] = 1'b1;
    end

    // Latch the lower byte whenever the upper byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_latch <= '0;
        else if (rd_hi) lo_latch <= word[BW-1:0];
    end

    // R7: at most one register is flagged as being read.
    a_r7_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> $onehot0(hit_hi));
endmodule

// File: rtl/cap_unit.sv
// Top of the buffered input-capture timer: counter, edge detectors, two
// channel pairs, read port, capture flags and interrupt.
// Assumes: cap_in is synchronised; flags clear only by read-then-write-0.
module cap_unit #(
    parameter int W  = cap_pkg::CNT_W,
    parameter int BW = cap_pkg::BYTE_W,
    localparam int N  = cap_pkg::N_CH,
    localparam int NP = cap_pkg::N_PAIR,
    localparam int AW = $clog2(N) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  cap_in,
    input  logic [N-1:0]  edge_sel,
    input  logic [NP-1:0] buf_mode,
    input  logic [N-1:0]  irq_en,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [BW-1:0] rd_data,
    input  logic          flag_rd,
    input  logic          flag_wr,
    input  logic [N-1:0]  flag_wdata,
    output logic [N-1:0]  flags,
    output logic          irq
);
    logic [W-1:0]   cnt;
    logic [N-1:0]   ev;
    logic [N-1:0]   set;
    logic [N-1:0]   hit_hi;
    logic [N-1:0]   armed;
    logic [N*W-1:0] caps;

    cap_counter #(.W(W)) i_cnt (.clk(clk), .rst_n(rst_n), .cnt(cnt));

    cap_edge #(.N(N)) i_edge (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(edge_sel), .ev(ev)
    );

    for (genvar p = 0; p < NP; p++) begin : g_pair
        cap_pair #(.W(W)) i_pair (
            .clk     (clk),
            .rst_n   (rst_n),
            .cnt     (cnt),
            .ev_main (ev[p]),
            .ev_part (ev[p+NP]),
            .buf_en  (buf_mode[p]),
            .rd_hit  (hit_hi[p] | hit_hi[p+NP]),
            .main_q  (caps[p*W +: W]),
            .part_q  (caps[(p+NP)*W +: W]),
            .set_main(set[p]),
            .set_part(set[p+NP])
        );
    end

    cap_rdport #(.W(W), .BW(BW), .N(N)) i_rd (
        .clk(clk), .rst_n(rst_n), .caps(caps), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .hit_hi(hit_hi)
    );

    // Arm flags seen as 1 on a flag read; any flag write disarms all.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= '0;
        else if (flag_wr) armed <= '0;
        else if (flag_rd) armed <= armed | flags;
    end

    // Set flags on capture; clear armed flags written as 0; set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= set | (flags & ~({N{flag_wr}} & armed & ~flag_wdata));
    end

    // Interrupt request from enabled flags.
    always_comb irq = |(flags & irq_en);

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R9: a capture always leaves its flag set, even against a clear.
        a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
        // R8: a flag that is not armed survives a write.
        a_r8_need_arm: assert property (@(posedge clk) disable iff (!rst_n)
            flags[i] && !armed[i] |=> flags[i]);
    end
endmodule

// File: tb/test_cap_unit.sv
// Self-checking bench for cap_unit: a table walk over channels and edge
// polarities, then directed tests for buffering, collisions and flags.
module test_cap_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cap_in = '0, edge_sel = '0, irq_en = '0, flag_wdata = '0;
    logic [1:0] buf_mode = '0;
    logic       rd_en = 1'b0, flag_rd = 1'b0, flag_wr = 1'b0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic [3:0] flags;
    logic       irq;
    logic [15:0] tb_cnt = '0;
    int n_chk = 0, n_fail = 0;

    // Table entries: {channel[1:0], rising}
    localparam logic [2:0] VEC [8] = '{3'b001, 3'b000, 3'b011, 3'b010,
                                       3'b101, 3'b100, 3'b111, 3'b110};

    always #5 clk = ~clk;

    // Bench's own model of the free-running counter (R1).
    always @(posedge clk) tb_cnt <= !rst_n ? 16'd0 : tb_cnt + 16'd1;

    cap_unit i_cap_unit (
        .clk(clk), .rst_n(rst_n), .cap_in(cap_in), .edge_sel(edge_sel),
        .buf_mode(buf_mode), .irq_en(irq_en), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .flag_rd(flag_rd), .flag_wr(flag_wr),
        .flag_wdata(flag_wdata), .flags(flags), .irq(irq)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_in(input int ch, input logic v);
        cap_in[ch] = v;
        tick();
    endtask

    task automatic read16(input int ch, output logic [15:0] v);
        rd_en = 1'b1;
        rd_addr = {2'(ch), 1'b0};
        #1 v[15:8] = rd_data;
        tick();
        rd_addr = {2'(ch), 1'b1};
        #1 v[7:0] = rd_data;
        rd_en = 1'b0;
    endtask

    task automatic clear_flags();
        flag_rd = 1'b1;
        tick();
        flag_rd = 1'b0;
        flag_wr = 1'b1;
        flag_wdata = 4'b0000;
        tick();
        flag_wr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] v, old, t, t1, t2, oldb;
        @(negedge clk);
        repeat (3) tick();
        rst_n = 1'b1;
        // R11 reset state
        chk("R11 flags", 16'(flags), 16'h0);
        chk("R11 irq", 16'(irq), 16'h0);
        read16(0, v);
        chk("R11 reg A", v, 16'h0);

        // R2/R3 table walk: each channel, both polarities, non-buffered
        for (int e = 0; e < 8; e++) begin
            int ch;
            logic rise;
            ch = int'(VEC[e][2:1]);
            rise = VEC[e][0];
            edge_sel[ch] = rise;
            read16(ch, old);
            t = tb_cnt;
            set_in(ch, 1'b1);
            read16(ch, v);
            chk($sformatf("R3 first change ch%0d", ch), v, rise ? t : old);
            chk($sformatf("R2 flag first ch%0d", ch), 16'(flags[ch]), 16'(rise));
            clear_flags();
            read16(ch, old);
            t = tb_cnt;
            set_in(ch, 1'b0);
            read16(ch, v);
            chk($sformatf("R2 second change ch%0d", ch), v, rise ? old : t);
            chk($sformatf("R3 flag second ch%0d", ch), 16'(flags[ch]), 16'(!rise));
            clear_flags();
        end

        // R7 upper read latches the lower byte against a later capture
        edge_sel = 4'b1111;
        read16(0, old);
        rd_en = 1'b1; rd_addr = 3'b000;
        tick();
        rd_en = 1'b0;
        set_in(0, 1'b1);
        rd_en = 1'b1; rd_addr = 3'b001;
        #1 chk("R7 latched low byte", 16'(rd_data), 16'(old[7:0]));
        rd_en = 1'b0;
        #1 chk("R7 idle read data", 16'(rd_data), 16'h0);
        set_in(0, 1'b0);
        clear_flags();

        // R4 buffered A/C shift
        buf_mode = 2'b01;
        t1 = tb_cnt; set_in(0, 1'b1); set_in(0, 1'b0);
        t2 = tb_cnt; set_in(0, 1'b1); set_in(0, 1'b0);
        read16(0, v); chk("R4 A newest", v, t2);
        read16(2, v); chk("R4 C previous", v, t1);
        chk("R4 flags A only", 16'(flags), 16'h1);
        clear_flags();

        // R5 partner edge in buffered mode; R10 interrupt
        irq_en = 4'b0100;
        set_in(2, 1'b1);
        chk("R5 flag C", 16'(flags[2]), 16'h1);
        chk("R10 irq on", 16'(irq), 16'h1);
        irq_en = 4'b0011;
        #1 chk("R10 irq masked", 16'(irq), 16'h0);
        read16(2, v); chk("R5 C unchanged", v, t1);
        set_in(2, 1'b0);
        clear_flags();
        irq_en = 4'b0000;

        // R6 collision on A/C: upper read of C with A capture
        rd_en = 1'b1; rd_addr = 3'b100;
        t = tb_cnt;
        cap_in[0] = 1'b1;
        tick();
        rd_en = 1'b0;
        chk("R6 flag A held", 16'(flags[0]), 16'h0);
        tick();
        chk("R6 flag A late", 16'(flags[0]), 16'h1);
        read16(0, v); chk("R6 A delayed value", v, t + 16'd1);
        read16(2, v); chk("R6 C got old A", v, t2);
        set_in(0, 1'b0);
        clear_flags();

        // R6 lower-byte read: no delay
        rd_en = 1'b1; rd_addr = 3'b001;
        t = tb_cnt;
        cap_in[0] = 1'b1;
        tick();
        rd_en = 1'b0;
        chk("R6 low read no delay flag", 16'(flags[0]), 16'h1);
        read16(0, v); chk("R6 low read no delay value", v, t);
        set_in(0, 1'b0);
        clear_flags();

        // R6 collision on B/D pair
        buf_mode = 2'b11;
        read16(1, oldb);
        rd_en = 1'b1; rd_addr = 3'b010;
        t = tb_cnt;
        cap_in[1] = 1'b1;
        tick();
        rd_en = 1'b0;
        tick();
        read16(1, v); chk("R6 B delayed value", v, t + 16'd1);
        read16(3, v); chk("R4 D got old B", v, oldb);
        set_in(1, 1'b0);
        clear_flags();

        // R8 write without arming does not clear
        buf_mode = 2'b00;
        set_in(1, 1'b1);
        flag_wr = 1'b1; flag_wdata = 4'b0000;
        tick();
        flag_wr = 1'b0;
        chk("R8 unarmed survives", 16'(flags[1]), 16'h1);
        flag_rd = 1'b1; tick(); flag_rd = 1'b0;
        flag_wr = 1'b1; flag_wdata = 4'b0010;
        tick();
        flag_wr = 1'b0;
        chk("R8 written 1 survives", 16'(flags[1]), 16'h1);
        // R9 set beats clear in the same clock
        flag_rd = 1'b1; tick(); flag_rd = 1'b0;
        set_in(1, 1'b0);
        edge_sel[1] = 1'b1;
        flag_wr = 1'b1; flag_wdata = 4'b0000;
        cap_in[1] = 1'b1;
        tick();
        flag_wr = 1'b0;
        chk("R9 set wins", 16'(flags[1]), 16'h1);
        clear_flags();
        chk("R8 armed clear", 16'(flags), 16'h0);
        set_in(1, 1'b0);

        // R1 wrap of the counter
        while (tb_cnt != 16'hFFFF) tick();
        set_in(3, 1'b1);
        set_in(2, 1'b1);
        read16(3, v); chk("R1 capture at top", v, 16'hFFFF);
        read16(2, v); chk("R1 capture after wrap", v, 16'h0000);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule